// File: doc/BRIEF.md
# Serially Addressed Configuration Register Target

This block is the target side of a three-wire serial configuration link driven by a host. The host clocks address, data and a command bit in on a serial clock, qualified by a low-active strobe. The block oversamples all three serial lines with a fast system clock. Each line passes through a two-flop synchroniser, and clock edges are found in the system clock domain. Every rising serial clock edge taken while the strobe is high pushes one bit into a running shift history. The rising edge taken while the strobe is low is the command bit. At that moment the low 8 history bits give the address and, for a write, the 32 bits before them give the data.

The block holds three read/write 32-bit configuration words. It also returns two read-only words taken from its inputs: a switch setting and a version word. A read loads the addressed word into an output shift register, which the host clocks out most significant bit first. A write of the value 1 to a dedicated address raises a system reset request for a fixed number of system clocks.

Top module: `cfgslv_top`

## Requirements
- R1: Bits are taken on serial clock rising edges while the strobe is high, most significant bit first. At a write command (strobe low, data line 1 on the rising edge), the 8 bits taken just before it are the address and the 32 bits before those are the data.
- R2: At a read command (strobe low, data line 0 on the rising edge), the addressed word is loaded. Its bit 31 is on `ser_miso_o` before the first rising edge after the strobe returns high. Each later serial falling edge advances one bit, except the falling edge of the command pulse itself. After all 32 bits, the output is 0.
- R3: Address 0x00 (mode), 0x01 (multiplexer) and 0x02 (display output) are read/write words that reset to 0 and read back the last value written.
- R4: Address 0x08 reads `switch_i` and address 0xFF reads `version_i`. Writes to either address change nothing.
- R5: A read of any other address returns 0. A write to any other address leaves all words unchanged.
- R6: A write of exactly 0x0000_0001 to address 0x80 drives `sys_rst_req_o` high for exactly RST_CYCLES system clocks. Any other value written there gives no pulse.
- R7: A read of address 0x80 always returns 0.
- R8: A strobe pulse without a serial clock rising edge, or any number of bits clocked in with the strobe high, changes no word and raises no reset request.
- R9: After reset, `ser_miso_o` and `sys_rst_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_stb_n_i | input | 1 | Active-low strobe marking the command bit |
| ser_mosi_i | input | 1 | Serial data from the host |
| ser_miso_o | output | 1 | Serial read data to the host |
| version_i | input | 32 | Read-only version word |
| switch_i | input | 32 | Read-only switch setting word |
| sys_rst_req_o | output | 1 | System reset request pulse |

## Verification
The directed writes use words with only the top bit set, only the bottom bit set, all ones, and an alternating pattern. Reading them back separates a correct bit order from a reversed or shifted order, and shows whether the address and data fields are taken from the right part of the history. Writes to read-only, unmapped and reset addresses are each followed by reads of the writable words, which shows whether a write reached the wrong word. Stray strobe pulses and frames with no command bit show whether anything other than the strobed command bit acts on the block. A seeded random mix of reads and writes over the whole address range, checked against a bench model, covers the order in which operations follow each other.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int HIST_W = DATA_W + ADDR_W;

    localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
    localparam logic [ADDR_W-1:0] A_MUX     = 8'h01;
    localparam logic [ADDR_W-1:0] A_DISP    = 8'h02;
    localparam logic [ADDR_W-1:0] A_SWITCH  = 8'h08;
    localparam logic [ADDR_W-1:0] A_SYSRST  = 8'h80;
    localparam logic [ADDR_W-1:0] A_VERSION = 8'hFF;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgslv_rx.sv
module cfgslv_rx
    import cfgslv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic stb_n_s,
    input  logic mosi_s,
    output logic sclk_fall,
    output cmd_t cmd_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic [HIST_W-1:0] hist;
        cmd_t              cmd;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      sclk_rise;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cmd.valid = 1'b0;
        if (sclk_rise) begin
            if (!stb_n_s) begin
                st_d.cmd.valid = 1'b1;
                st_d.cmd.write = mosi_s;
                st_d.cmd.addr  = st_q.hist[ADDR_W-1:0];
                st_d.cmd.data  = st_q.hist[HIST_W-1:ADDR_W];
            end else begin
                st_d.hist = {st_q.hist[HIST_W-2:0], mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o = st_q.cmd;
endmodule

// File: rtl/cfgslv_regs.sv
module cfgslv_regs
    import cfgslv_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd_i,
    input  logic [DATA_W-1:0] version_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic [DATA_W-1:0] disp_o,
    output logic              rst_req_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] mux;
        logic [DATA_W-1:0] disp;
        logic [CNT_W-1:0]  cnt;
        logic              req;
    } reg_state_t;

    reg_state_t st_q, st_d;
    logic       wr, trig;

    assign wr   = cmd_i.valid & cmd_i.write;
    assign trig = wr && (cmd_i.addr == A_SYSRST) && (cmd_i.data == DATA_W'(1));

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (cmd_i.addr)
                A_MODE:  st_d.mode = cmd_i.data;
                A_MUX:   st_d.mux  = cmd_i.data;
                A_DISP:  st_d.disp = cmd_i.data;
                default: ;
            endcase
        end
        if (trig) begin
            st_d.req = 1'b1;
            st_d.cnt = CNT_W'(RST_CYCLES - 1);
        end else if (st_q.req) begin
            if (st_q.cnt == '0) st_d.req = 1'b0;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_comb begin
        case (cmd_i.addr)
            A_MODE:    rd_data_o = st_q.mode;
            A_MUX:     rd_data_o = st_q.mux;
            A_DISP:    rd_data_o = st_q.disp;
            A_SWITCH:  rd_data_o = switch_i;
            A_VERSION: rd_data_o = version_i;
            default:   rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign mux_o     = st_q.mux;
    assign disp_o    = st_q.disp;
    assign rst_req_o = st_q.req;
endmodule

// File: rtl/cfgslv_tx.sv
module cfgslv_tx
    import cfgslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              sclk_fall_i,
    output logic              miso_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              skip;
    } tx_state_t;

    tx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh   = load_data_i;
            st_d.skip = 1'b1;
        end else if (sclk_fall_i) begin
            if (st_q.skip) st_d.skip = 1'b0;
            else           st_d.sh   = {st_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o = st_q.sh[DATA_W-1];
endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
    import cfgslv_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_stb_n_i,
    input  logic              ser_mosi_i,
    output logic              ser_miso_o,
    input  logic [DATA_W-1:0] version_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic              sys_rst_req_o
);
    logic [2:0]        sync_w;
    logic              sclk_fall;
    cmd_t              cmd;
    logic [DATA_W-1:0] rd_data, mode_val, mux_val, disp_val;

    cfgslv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ser_stb_n_i, ser_mosi_i}),
        .sync_o  (sync_w)
    );

    cfgslv_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sync_w[2]),
        .stb_n_s   (sync_w[1]),
        .mosi_s    (sync_w[0]),
        .sclk_fall (sclk_fall),
        .cmd_o     (cmd)
    );

    cfgslv_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .version_i (version_i),
        .switch_i  (switch_i),
        .rd_data_o (rd_data),
        .mode_o    (mode_val),
        .mux_o     (mux_val),
        .disp_o    (disp_val),
        .rst_req_o (sys_rst_req_o)
    );

    cfgslv_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cmd.valid & ~cmd.write),
        .load_data_i (rd_data),
        .sclk_fall_i (sclk_fall),
        .miso_o      (ser_miso_o)
    );
endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk
    import cfgslv_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input cmd_t              cmd,
    input logic [DATA_W-1:0] mode_val,
    input logic [DATA_W-1:0] mux_val,
    input logic [DATA_W-1:0] disp_val,
    input logic              sys_rst_req_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 2);

    logic             wr, trig;
    logic [CNT_W-1:0] hi_cnt_q;

    assign wr   = cmd.valid & cmd.write;
    assign trig = wr && cmd.addr == A_SYSRST && cmd.data == DATA_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_cnt_q <= '0;
        else if (trig)          hi_cnt_q <= '0;
        else if (sys_rst_req_o) hi_cnt_q <= hi_cnt_q + 1'b1;
        else                    hi_cnt_q <= '0;
    end

    p_mode_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr && cmd.addr == A_MODE |=> mode_val == $past(cmd.data));

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && cmd.addr == A_MODE) |=> $stable(mode_val));

    p_mux_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && cmd.addr == A_MUX) |=> $stable(mux_val));

    p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && cmd.addr == A_DISP) |=> $stable(disp_val));

    p_rst_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> sys_rst_req_o);

    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req_o) |-> $past(trig));

    p_rst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_req_o) |-> hi_cnt_q == CNT_W'(RST_CYCLES));

    p_rst_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q <= CNT_W'(RST_CYCLES));
endmodule

bind cfgslv_top cfgslv_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .mode_val      (mode_val),
    .mux_val       (mux_val),
    .disp_val      (disp_val),
    .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/tb_cfgslv_top.sv
`timescale 1ns/1ps
module tb_cfgslv_top;
    localparam int N  = 16;
    localparam int HP = 6;
    localparam logic [31:0] VER = 32'hC0DE_0107;
    localparam logic [31:0] SW  = 32'h0000_005A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, stb_n = 1'b1, mosi = 1'b0;
    logic miso, rreq;
    int   n_chk = 0, n_fail = 0;
    int   run = 0, pulses = 0, last_len = 0;
    logic [31:0] m_mode = '0, m_mux = '0, m_disp = '0;

    always #5 clk = ~clk;

    cfgslv_top #(.RST_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_stb_n_i(stb_n),
        .ser_mosi_i(mosi), .ser_miso_o(miso), .version_i(VER),
        .switch_i(SW), .sys_rst_req_o(rreq)
    );

    always @(negedge clk) begin
        if (rreq) run <= run + 1;
        else if (run != 0) begin
            pulses   <= pulses + 1;
            last_len <= run;
            run      <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (HP) @(negedge clk);
    endtask

    task automatic pulse_clk();
        sclk = 1'b1; half(); sclk = 1'b0; half();
    endtask

    task automatic send_bits(input logic [31:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            mosi = v[i]; half(); pulse_clk();
        end
    endtask

    task automatic command(input logic wbit);
        mosi = wbit; stb_n = 1'b0; half();
        pulse_clk();
        stb_n = 1'b1; half();
    endtask

    task automatic ser_write(input logic [7:0] a, input logic [31:0] d);
        send_bits(d, 32);
        send_bits({24'h0, a}, 8);
        command(1'b1);
        case (a)
            8'h00: m_mode = d;
            8'h01: m_mux  = d;
            8'h02: m_disp = d;
            default: ;
        endcase
    endtask

    task automatic ser_read(input logic [7:0] a, output logic [31:0] d);
        send_bits({24'h0, a}, 8);
        command(1'b0);
        for (int i = 31; i >= 0; i--) begin
            d[i] = miso;
            pulse_clk();
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [7:0] a);
        case (a)
            8'h00:   return m_mode;
            8'h01:   return m_mux;
            8'h02:   return m_disp;
            8'h08:   return SW;
            8'hFF:   return VER;
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [31:0] d;
        ser_read(a, d);
        chk(req, d, expect_rd(a));
    endtask

    initial begin
        logic [7:0]  a;
        logic [31:0] d;
        int          p0;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 miso after reset", {31'h0, miso}, 32'h0);
        chk("R9 reset request after reset", {31'h0, rreq}, 32'h0);

        ser_read(8'hFF, d);              // first access, treated as a dummy
        rd_chk("R4 version read", 8'hFF);
        rd_chk("R4 switch read", 8'h08);
        rd_chk("R3 mode reset value", 8'h00);
        rd_chk("R3 mux reset value", 8'h01);
        rd_chk("R3 display reset value", 8'h02);

        ser_write(8'h00, 32'h8000_0000);
        rd_chk("R1 R2 mode top bit only", 8'h00);
        ser_write(8'h01, 32'h0000_0001);
        rd_chk("R1 R2 mux bottom bit only", 8'h01);
        ser_write(8'h02, 32'hFFFF_FFFF);
        rd_chk("R1 R3 display all ones", 8'h02);
        ser_write(8'h00, 32'hA5C3_0F96);
        rd_chk("R1 R2 mode mixed pattern", 8'h00);
        chk("R2 output idle after read", {31'h0, miso}, 32'h0);

        ser_write(8'h08, 32'h1234_5678);
        ser_write(8'hFF, 32'h1234_5678);
        rd_chk("R4 switch write ignored", 8'h08);
        rd_chk("R4 version write ignored", 8'hFF);

        ser_write(8'h03, 32'hDEAD_BEEF);
        ser_write(8'h7F, 32'hDEAD_BEEF);
        rd_chk("R5 unmapped reads zero", 8'h03);
        rd_chk("R5 mode unchanged by unmapped write", 8'h00);
        rd_chk("R5 mux unchanged by unmapped write", 8'h01);
        rd_chk("R5 display unchanged by unmapped write", 8'h02);

        p0 = pulses;
        ser_write(8'h80, 32'h0000_0002);
        repeat (N + 20) @(negedge clk);
        chk("R6 no pulse for value 2", pulses - p0, 0);
        ser_write(8'h80, 32'h8000_0001);
        repeat (N + 20) @(negedge clk);
        chk("R6 no pulse for high bit plus one", pulses - p0, 0);
        rd_chk("R7 reset address reads zero", 8'h80);

        ser_write(8'h80, 32'h0000_0001);
        repeat (N + 20) @(negedge clk);
        chk("R6 one pulse after reset write", pulses - p0, 1);
        chk("R6 pulse length", last_len, N);
        rd_chk("R7 reset address reads zero after pulse", 8'h80);

        p0 = pulses;
        stb_n = 1'b0; mosi = 1'b1; half(); stb_n = 1'b1; half();
        send_bits(32'h0000_0001, 32);
        send_bits(32'h0000_0080, 8);
        send_bits(32'hFFFF_0000, 32);
        send_bits(32'h0000_0000, 8);
        repeat (N + 20) @(negedge clk);
        chk("R8 no pulse without command bit", pulses - p0, 0);
        rd_chk("R8 mode unchanged without command bit", 8'h00);

        for (int k = 0; k < 40; k++) begin
            case ($urandom_range(0, 6))
                0: a = 8'h00;
                1: a = 8'h01;
                2: a = 8'h02;
                3: a = 8'h08;
                4: a = 8'hFF;
                5: a = 8'h80;
                default: a = 8'($urandom);
            endcase
            d = $urandom;
            if (d == 32'h1) d = 32'h3;
            if ($urandom_range(0, 1) == 1) ser_write(a, d);
            else rd_chk("R1 R2 R5 random read", a);
        end
        chk("R6 no pulse in random traffic", pulses - p0, 0);
        rd_chk("R3 final mode", 8'h00);
        rd_chk("R3 final mux", 8'h01);
        rd_chk("R3 final display", 8'h02);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule